// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block gathers thirty-two interrupt request lines into two processor-facing outputs: a normal interrupt and a critical interrupt. Each request line can be set to edge or level sensitivity, enabled individually, and steered to either output. Software reaches the block through a small register port. It takes a 4-bit register offset, a write strobe with 32-bit write data, and a combinational 32-bit read bus that always returns the register at the current offset.

Pending sources sit in a status word. Request line n occupies status bit 31-n, so line 0 is the most significant bit. Software clears status bits through one offset and sets them through another. A level source that is still asserted cannot be cleared. When the vector parameter is on, the block also provides a vector address for the critical source that wins the priority search. The address is a programmable base plus 512 times that source's priority index, and a configuration bit picks the direction of the search. The polarity register is stored and read back but does not act on the inputs.

Top module: `intc_unit`

## Requirements
- R1: After reset every register reads 0 (offsets 0 to 8) and both `int_o` and `crit_o` are low.
- R2: Request line n maps to status bit 31-n. With its trigger bit at 1 (edge), a rising input sets the status bit, and a falling input leaves it set.
- R3: With its trigger bit at 0 (level), the status bit follows the input. A status-clear write cannot remove a bit whose level input is still high.
- R4: Writing offset 0 clears every status bit written as 1. Writing offset 1 ORs the data into status. Reads of offset 0 and offset 1 both return the status word.
- R5: Offset 6 reads status AND enable. Writes to offset 6 and to offset 7 change nothing.
- R6: `int_o` is high when status AND enable AND NOT critical-select (offset 3) is nonzero. `crit_o` is high when status AND enable AND critical-select is nonzero.
- R7: A write to the vector configuration (offset 8) stores the data with bit 1 forced to 0.
- R8: With configuration bit 0 at 0, the vector (offset 7) equals (configuration AND 0xFFFFFFFC) + 512*k, where k is the lowest set bit index of the pending critical word (status AND enable AND critical-select).
- R9: With configuration bit 0 at 1, the vector equals (configuration AND 0xFFFFFFFC) + 512*(31-k), where k is the highest set bit index of the pending critical word.
- R10: The vector reads 0 when no critical source is pending. Offsets 9 to 15 read 0.
- R11: A change on a request line appears on the outputs one clock later, not in the same cycle.
- R12: The polarity register (offset 4) reads back what was written and has no effect on status or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_i | input | 32 | Interrupt request lines |
| int_o | output | 1 | Normal interrupt |
| crit_o | output | 1 | Critical interrupt |

## Verification
The bench drives each of the thirty-two lines in turn. A design with reversed bit mapping would set the wrong status bit. One that lost edge latching would drop the bit when the input falls. One that reacted without a register stage would raise `int_o` in the same cycle as the input change.

The level-source tests clear status while the input is still high. A design that forgot to reapply the level state would show the bit cleared.

The vector is checked for every single-bit pending word and for several multi-bit words, in both search directions. An inverted index, a wrong stride, or a base that kept its low two bits would give a wrong address. The bench also writes the read-only offsets, the vector configuration with bit 1 set, and unmapped offsets, so a design that stored any of these values would read back nonzero.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    OFS_STAT  = 4'd0,
    OFS_SET   = 4'd1,
    OFS_EN    = 4'd2,
    OFS_CRIT  = 4'd3,
    OFS_POL   = 4'd4,
    OFS_TRIG  = 4'd5,
    OFS_MSTAT = 4'd6,
    OFS_VEC   = 4'd7,
    OFS_VCFG  = 4'd8
  } reg_ofs_e;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/intc_src_latch.sv
module intc_src_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] trig,
  input  logic         clr_we,
  input  logic [N-1:0] clr_val,
  input  logic         set_we,
  input  logic [N-1:0] set_val,
  output logic [N-1:0] status,
  output logic [N-1:0] src_prev
);
  logic [N-1:0] status_q, status_d;
  logic [N-1:0] lvl_q, lvl_d;
  logic [N-1:0] prev_q;
  logic [N-1:0] base;

  always_comb begin
    base = status_q;
    if (clr_we) base = (base & ~clr_val) | lvl_q;
    if (set_we) base = base | set_val;
    for (int b = 0; b < N; b++) begin
      status_d[b] = base[b];
      lvl_d[b]    = lvl_q[b];
      if (trig[b]) begin
        if (src[b] && !prev_q[b]) status_d[b] = 1'b1;
      end else begin
        lvl_d[b] = src[b];
        if (src[b] != prev_q[b]) status_d[b] = src[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      lvl_q    <= '0;
      prev_q   <= '0;
    end else begin
      status_q <= status_d;
      lvl_q    <= lvl_d;
      prev_q   <= src;
    end
  end

  assign status   = status_q;
  assign src_prev = prev_q;
endmodule

// File: rtl/intc_prio_vec.sv
module intc_prio_vec #(
  parameter int unsigned N         = 32,
  parameter int unsigned STRIDE_LG = 9
) (
  input  logic [N-1:0] pend,
  input  logic         dir_down,
  input  logic [N-1:0] base,
  output logic [N-1:0] vec
);
  localparam int unsigned IW = $clog2(N);

  logic          hit;
  logic [IW-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int j = 0; j < N; j++) begin
      if (!hit && (dir_down ? pend[N-1-j] : pend[j])) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end

  assign vec = hit ? ({base[N-1:2], 2'b00} + (N'(idx) << STRIDE_LG)) : '0;
endmodule

// File: rtl/intc_unit.sv
module intc_unit #(
  parameter int unsigned NSRC      = 32,
  parameter bit          VEC_EN    = 1'b1,
  parameter int unsigned STRIDE_LG = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic [NSRC-1:0] irq_i,
  output logic            int_o,
  output logic            crit_o
);
  import intc_pkg::*;

  logic            rst_sync_n;
  logic [NSRC-1:0] src, src_prev, status;
  logic [NSRC-1:0] en_q, en_d, crit_q, crit_d, pol_q, pol_d, trig_q, trig_d;
  logic [NSRC-1:0] vcfg_q, vec;
  logic [NSRC-1:0] pend_n, pend_c;
  logic            wr_stat, wr_set, wr_en, wr_crit, wr_pol, wr_trig, wr_vcfg;

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign src[NSRC-1-n] = irq_i[n];
  end

  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_set  = reg_we && (reg_addr == OFS_SET);
  assign wr_en   = reg_we && (reg_addr == OFS_EN);
  assign wr_crit = reg_we && (reg_addr == OFS_CRIT);
  assign wr_pol  = reg_we && (reg_addr == OFS_POL);
  assign wr_trig = reg_we && (reg_addr == OFS_TRIG);
  assign wr_vcfg = reg_we && (reg_addr == OFS_VCFG);

  intc_src_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .src(src), .trig(trig_q),
    .clr_we(wr_stat), .clr_val(reg_wdata),
    .set_we(wr_set), .set_val(reg_wdata),
    .status(status), .src_prev(src_prev)
  );

  always_comb begin
    en_d   = wr_en   ? reg_wdata : en_q;
    crit_d = wr_crit ? reg_wdata : crit_q;
    pol_d  = wr_pol  ? reg_wdata : pol_q;
    trig_d = wr_trig ? reg_wdata : trig_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      en_q   <= en_d;
      crit_q <= crit_d;
      pol_q  <= pol_d;
      trig_q <= trig_d;
    end
  end

  assign pend_n = status & en_q & ~crit_q;
  assign pend_c = status & en_q & crit_q;
  assign int_o  = |pend_n;
  assign crit_o = |pend_c;

  if (VEC_EN) begin : g_vec
    logic [NSRC-1:0] vcfg_d;

    always_comb begin
      vcfg_d = vcfg_q;
      if (wr_vcfg) vcfg_d = reg_wdata & ~NSRC'(2);
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) vcfg_q <= '0;
      else             vcfg_q <= vcfg_d;
    end

    intc_prio_vec #(.N(NSRC), .STRIDE_LG(STRIDE_LG)) u_vec (
      .pend(pend_c), .dir_down(vcfg_q[0]), .base(vcfg_q), .vec(vec)
    );
  end else begin : g_novec
    assign vcfg_q = '0;
    assign vec    = '0;
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT, OFS_SET: reg_rdata = status;
      OFS_EN:            reg_rdata = en_q;
      OFS_CRIT:          reg_rdata = crit_q;
      OFS_POL:           reg_rdata = pol_q;
      OFS_TRIG:          reg_rdata = trig_q;
      OFS_MSTAT:         reg_rdata = status & en_q;
      OFS_VEC:           reg_rdata = vec;
      OFS_VCFG:          reg_rdata = vcfg_q;
      default:           reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_unit_chk.sv
module intc_unit_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_ok,
  input logic [3:0]   reg_addr,
  input logic         reg_we,
  input logic [N-1:0] reg_wdata,
  input logic [N-1:0] src,
  input logic [N-1:0] src_prev,
  input logic [N-1:0] status,
  input logic [N-1:0] trig,
  input logic [N-1:0] en,
  input logic [N-1:0] vcfg,
  input logic [N-1:0] vec,
  input logic         int_o,
  input logic         crit_o
);
  logic [N-1:0] clr_mask, set_mask, lv_chg, edge_keep;

  assign clr_mask  = (reg_we && reg_addr == 4'd0) ? reg_wdata : '0;
  assign set_mask  = (reg_we && reg_addr == 4'd1) ? reg_wdata : '0;
  assign lv_chg    = ~trig & (src ^ src_prev);
  assign edge_keep = status & trig & ~clr_mask;

  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status & $past(edge_keep)) == $past(edge_keep)));

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status & $past(lv_chg)) == ($past(src) & $past(lv_chg))));

  p_set_write_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((status & $past(set_mask & ~lv_chg)) == $past(set_mask & ~lv_chg)));

  p_int_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (int_o || crit_o) |-> ((status & en) != '0));

  p_vcfg_bit1_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    vcfg[1] == 1'b0);

  p_vec_idle_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !crit_o |-> (vec == '0));

  p_vec_align_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    vec[1:0] == 2'b00);
endmodule

bind intc_unit intc_unit_chk #(.N(NSRC)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .src(src), .src_prev(src_prev), .status(status),
  .trig(trig_q), .en(en_q), .vcfg(vcfg_q), .vec(vec),
  .int_o(int_o), .crit_o(crit_o)
);

// File: tb/intc_unit_test.sv
module intc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] irq_i;
  logic        int_o, crit_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  intc_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_i(irq_i),
    .int_o(int_o), .crit_o(crit_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int lowest(input logic [31:0] p);
    for (int k = 31; k >= 0; k--) if (p[k]) lowest = k;
  endfunction

  function automatic int highest(input logic [31:0] p);
    for (int k = 0; k < 32; k++) if (p[k]) highest = k;
  endfunction

  task automatic vec_case(input logic [31:0] p, input logic [31:0] cfg);
    logic [31:0] v, exp;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd8, cfg);
    wr(4'd1, p);
    exp = (cfg & 32'hFFFF_FFFC) + (cfg[0] ? 32'(31 - highest(p)) : 32'(lowest(p))) * 512;
    rd(4'd7, v);
    chk(cfg[0] ? "R9 vector descending" : "R8 vector ascending", v, exp);
    chk("R6 crit_o on", {31'd0, crit_o}, 32'd1);
    chk("R6 int_o off", {31'd0, int_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), v);
      chk("R1 reset register", v, 32'd0);
    end
    chk("R1 int_o reset", {31'd0, int_o}, 32'd0);
    chk("R1 crit_o reset", {31'd0, crit_o}, 32'd0);

    // R10 unmapped offsets
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), v);
      chk("R10 unmapped reads 0", v, 32'd0);
    end

    // R7 configuration bit 1 forced low
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v);
    chk("R7 vcfg bit1", v, 32'hFFFF_FFFD);
    wr(4'd8, 32'd0);

    // R12 polarity stored only
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd4, 32'hA5A5_5A5A);
    rd(4'd4, v);
    chk("R12 polarity readback", v, 32'hA5A5_5A5A);
    rd(4'd0, v);
    chk("R12 polarity no status", v, 32'd0);
    chk("R12 polarity no int", {31'd0, int_o}, 32'd0);
    wr(4'd4, 32'd0);

    // R2 / R11 edge sweep over all lines
    wr(4'd5, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      irq_i = 32'd1 << n;
      #1;
      chk("R11 no same-cycle output", {31'd0, int_o}, 32'd0);
      @(negedge clk);
      chk("R11 output next cycle", {31'd0, int_o}, 32'd1);
      rd(4'd0, v);
      chk("R2 edge sets status bit", v, 32'd1 << (31 - n));
      irq_i = '0;
      @(negedge clk);
      rd(4'd0, v);
      chk("R2 edge bit held after fall", v, 32'd1 << (31 - n));
      wr(4'd0, 32'd1 << (31 - n));
      rd(4'd0, v);
      chk("R4 clear edge bit", v, 32'd0);
      chk("R4 int_o after clear", {31'd0, int_o}, 32'd0);
    end

    // R4 set/clear and alias read
    wr(4'd1, 32'h1234_5678);
    rd(4'd0, v);
    chk("R4 set via offset 1", v, 32'h1234_5678);
    rd(4'd1, v);
    chk("R4 offset 1 reads status", v, 32'h1234_5678);
    wr(4'd0, 32'h1030_5070);
    rd(4'd0, v);
    chk("R4 partial clear", v, 32'h0204_0608);

    // R5 masked status and ignored writes
    wr(4'd2, 32'h0000_FFFF);
    rd(4'd6, v);
    chk("R5 masked status", v, 32'h0000_0608);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd6, v);
    chk("R5 write to masked ignored", v, 32'h0000_0608);
    rd(4'd0, v);
    chk("R5 status untouched", v, 32'h0204_0608);
    rd(4'd7, v);
    chk("R5 vector write ignored", v, 32'd0);
    wr(4'd2, 32'h0200_0000);
    rd(4'd6, v);
    chk("R5 masked status high", v, 32'h0200_0000);
    wr(4'd0, 32'hFFFF_FFFF);

    // R3 level sources
    wr(4'd5, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n += 5) begin
      @(negedge clk);
      irq_i = 32'd1 << n;
      @(negedge clk);
      rd(4'd0, v);
      chk("R3 level sets", v, 32'd1 << (31 - n));
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, v);
      chk("R3 active level survives clear", v, 32'd1 << (31 - n));
      chk("R3 int_o stays", {31'd0, int_o}, 32'd1);
      irq_i = '0;
      @(negedge clk);
      rd(4'd0, v);
      chk("R3 level follows fall", v, 32'd0);
    end

    // R6 normal vs critical routing
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_FFFF);
    wr(4'd1, 32'h0001_0000);
    chk("R6 normal int_o", {31'd0, int_o}, 32'd1);
    chk("R6 normal crit_o", {31'd0, crit_o}, 32'd0);
    rd(4'd7, v);
    chk("R10 vector idle", v, 32'd0);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0000_0001);
    chk("R6 critical crit_o", {31'd0, crit_o}, 32'd1);
    chk("R6 critical int_o", {31'd0, int_o}, 32'd0);
    wr(4'd2, 32'hFFFF_FFFE);
    chk("R6 disabled crit_o", {31'd0, crit_o}, 32'd0);
    rd(4'd7, v);
    chk("R10 vector zero when disabled", v, 32'd0);
    wr(4'd0, 32'hFFFF_FFFF);

    // R8 / R9 vector sweep
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      vec_case(32'd1 << k, 32'hABCD_0002);
      vec_case(32'd1 << k, 32'hABCD_0003);
    end
    vec_case(32'h8000_0101, 32'h4000_0000);
    vec_case(32'h8000_0101, 32'h4000_0001);
    vec_case(32'h0F0F_0000, 32'h0000_1000);
    vec_case(32'h0F0F_0000, 32'h0000_1001);
    vec_case(32'hFFFF_FFFF, 32'hFFFF_0001);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd7, v);
    chk("R10 vector after clear", v, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule